// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block runs through a linked list of transfer descriptors kept in system memory and turns each one into a single request for a downstream data mover. Every descriptor is 16 bytes: four 32-bit words that the walker reads one at a time over a simple request/ready word-read port. The walker decodes the buffer address, converts the quadword length into a byte count, takes the direction, bus-mode flag, mode number and burst size from the flags word, and then holds one request toward the mover until the mover reports completion or failure.

After a transfer completes, the walker stops if the entry carries the end mark. Otherwise it follows the entry's next pointer. A next pointer of zero on an unmarked entry, a zero length, or an error from the mover ends the walk with a failure pulse, an error code and the zero-based position of the offending entry. Software or a command engine starts the walk by pulsing `start` with the address of the first entry.

Top module: `sg_chain_walker`

## Requirements
- R1: A descriptor at base address B is read with four word reads at B, B+4, B+8 and B+12, in that order. The words are buffer address, length, flags and next pointer. Each read holds `rd_req` and a stable `rd_addr` until `rd_ready` is high at a clock edge, and `rd_data` is taken at that edge.
- R2: The length word counts 8-byte quadwords, and `xfer_bytes` equals length × 8.
- R3: The flags word is decoded as follows: bit 4 drives `xfer_udma`, bit 5 drives `xfer_write`, bits 11:8 give `xfer_mode` and bits 15:12 give `xfer_burst` (in 512-byte units). `xfer_addr` is the buffer address word.
- R4: Each valid descriptor produces exactly one request. `xfer_req` stays high and its fields stay stable until `xfer_done` or `xfer_err` is seen.
- R5: An entry with flags bit 7 set ends the walk with a `done` pulse after its transfer completes, even when its next pointer is non-zero.
- R6: After an unmarked entry completes with a non-zero next pointer, the next fetch starts at that pointer and the entry index goes up by one.
- R7: An unmarked entry whose next pointer is zero ends the walk after its transfer, with `fail`, `err_code`=2 and `err_index` set to that entry.
- R8: A zero length raises `fail` with `err_code`=1 and that entry's index, and no request is issued for that entry.
- R9: `xfer_err` ends the walk with `fail`, `err_code`=3 and the current index. When `xfer_err` and `xfer_done` are high together, the error takes priority.
- R10: A `start` pulse that arrives while `busy` is high has no effect on the walk in progress.
- R11: After reset, `busy`, `rd_req`, `xfer_req`, `done` and `fail` are all low. `busy` goes high in the cycle after `start` is accepted and goes low in the same cycle as the completion pulse.
- R12: `done` and `fail` are one-cycle pulses and are never high together. `err_code` is 0 after `done`. `err_index` is zero-based and is cleared when a walk starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| head_addr | input | ADDR_W | Byte address of the first descriptor |
| rd_req | output | 1 | Word read request |
| rd_addr | output | ADDR_W | Word read byte address |
| rd_ready | input | 1 | Read accepted, `rd_data` valid |
| rd_data | input | 32 | Read data word |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_addr | output | ADDR_W | Buffer address |
| xfer_bytes | output | 35 | Transfer size in bytes |
| xfer_write | output | 1 | Transfer toward the device |
| xfer_udma | output | 1 | Use the UDMA bus protocol |
| xfer_mode | output | 4 | Bus transfer mode number |
| xfer_burst | output | 4 | Burst size in 512-byte units |
| xfer_done | input | 1 | Transfer finished |
| xfer_err | input | 1 | Transfer failed |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Chain completed (pulse) |
| fail | output | 1 | Walk aborted (pulse) |
| err_code | output | 2 | 0 none, 1 zero length, 2 broken chain, 3 mover error |
| err_index | output | IDX_W | Index of the entry that ended the walk |

## Verification
Some properties are checked by assertions on every cycle. These are: the read request holds and steps by four bytes, requests stay stable until they are answered, no zero-byte request is issued, the read and transfer ports are never active together, the completion pulses stay exclusive, a followed pointer appears as the next fetch address, and the end mark and the mover error map to the right pulse. The bench scenarios are needed for everything that depends on memory contents and ordering across a whole chain. That covers the decoded field values per entry, stopping on the end mark despite a live pointer, the broken-chain and zero-length aborts at the right index, the error-over-done priority, and a second start that must be ignored.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int BYTES_W = 35;

  localparam int FLAG_UDMA  = 4;
  localparam int FLAG_WRITE = 5;
  localparam int FLAG_LAST  = 7;
  localparam int MODE_LSB   = 8;
  localparam int BURST_LSB  = 12;

  localparam logic [1:0] ERR_NONE     = 2'd0;
  localparam logic [1:0] ERR_ZERO_LEN = 2'd1;
  localparam logic [1:0] ERR_CHAIN    = 2'd2;
  localparam logic [1:0] ERR_MOVER    = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_CHECK, ST_MOVE} sgw_state_e;

  typedef struct packed {
    logic [31:0] link;
    logic [31:0] flags;
    logic [31:0] qwords;
    logic [31:0] buf_addr;
  } sgw_desc_t;

  // quadword count to byte count
  function automatic logic [BYTES_W-1:0] qwords_to_bytes(input logic [31:0] q);
    return {q, 3'b000};
  endfunction
endpackage

// File: rtl/sgw_fetch.sv
module sgw_fetch
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              en,
  input  logic              rd_ready,
  input  logic [31:0]       rd_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output sgw_desc_t         desc,
  output logic              got_all
);
  localparam int WORDS = 4;
  localparam int WSEL_W = $clog2(WORDS);

  logic [ADDR_W-1:0] base_q;
  logic [WSEL_W-1:0] wsel_q;
  logic [31:0]       word_q [WORDS];
  logic              take;

  assign take    = en && rd_ready;
  assign rd_req  = en;
  assign rd_addr = base_q + ADDR_W'({wsel_q, 2'b00});
  assign got_all = take && (wsel_q == WSEL_W'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      wsel_q <= '0;
    end else if (load) begin
      base_q <= load_addr;
      wsel_q <= '0;
    end else if (take) begin
      wsel_q <= wsel_q + 1'b1;
    end
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) word_q[k] <= '0;
      else if (take && wsel_q == WSEL_W'(k)) word_q[k] <= rd_data;
    end
  end

  assign desc.buf_addr = word_q[0];
  assign desc.qwords   = word_q[1];
  assign desc.flags    = word_q[2];
  assign desc.link     = word_q[3];
endmodule

// File: rtl/sgw_decode.sv
module sgw_decode
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  sgw_desc_t          desc,
  output logic [ADDR_W-1:0]  buf_addr,
  output logic [BYTES_W-1:0] bytes,
  output logic               is_write,
  output logic               is_udma,
  output logic [3:0]         mode,
  output logic [3:0]         burst,
  output logic               is_last,
  output logic               len_zero,
  output logic               next_zero,
  output logic [ADDR_W-1:0]  next_addr
);
  logic unused_flag_bits;

  assign buf_addr  = desc.buf_addr[ADDR_W-1:0];
  assign bytes     = qwords_to_bytes(desc.qwords);
  assign len_zero  = (desc.qwords == '0);
  assign is_udma   = desc.flags[FLAG_UDMA];
  assign is_write  = desc.flags[FLAG_WRITE];
  assign is_last   = desc.flags[FLAG_LAST];
  assign mode      = desc.flags[MODE_LSB +: 4];
  assign burst     = desc.flags[BURST_LSB +: 4];
  assign next_addr = desc.link[ADDR_W-1:0];
  assign next_zero = (desc.link == '0);

  assign unused_flag_bits = ^{desc.flags[31:16], desc.flags[6], desc.flags[3:0]};
endmodule

// File: rtl/sgw_ctrl.sv
module sgw_ctrl
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic              got_all,
  input  logic              len_zero,
  input  logic              is_last,
  input  logic              next_zero,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic              xfer_done,
  input  logic              xfer_err,
  output logic              fetch_en,
  output logic              load,
  output logic [ADDR_W-1:0] load_addr,
  output logic              advance,
  output logic              xfer_req,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [1:0]        err_code,
  output logic [IDX_W-1:0]  err_index
);
  sgw_state_e st_q, st_nx;
  logic       ok_done;

  assign ok_done   = (st_q == ST_MOVE) && xfer_done && !xfer_err;
  assign advance   = ok_done && !is_last && !next_zero;
  assign load      = ((st_q == ST_IDLE) && start) || advance;
  assign load_addr = (st_q == ST_IDLE) ? head_addr : next_addr;
  assign fetch_en  = (st_q == ST_FETCH);
  assign xfer_req  = (st_q == ST_MOVE);
  assign busy      = (st_q != ST_IDLE);

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      ST_IDLE:  if (start) st_nx = ST_FETCH;
      ST_FETCH: if (got_all) st_nx = ST_CHECK;
      ST_CHECK: st_nx = len_zero ? ST_IDLE : ST_MOVE;
      ST_MOVE: begin
        if (xfer_err) st_nx = ST_IDLE;
        else if (xfer_done) st_nx = (is_last || next_zero) ? ST_IDLE : ST_FETCH;
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      done      <= 1'b0;
      fail      <= 1'b0;
      err_code  <= ERR_NONE;
      err_index <= '0;
    end else begin
      st_q <= st_nx;
      done <= 1'b0;
      fail <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          err_code  <= ERR_NONE;
          err_index <= '0;
        end
        ST_CHECK: if (len_zero) begin
          fail     <= 1'b1;
          err_code <= ERR_ZERO_LEN;
        end
        ST_MOVE: begin
          if (xfer_err) begin
            fail     <= 1'b1;
            err_code <= ERR_MOVER;
          end else if (xfer_done) begin
            if (is_last) done <= 1'b1;
            else if (next_zero) begin
              fail     <= 1'b1;
              err_code <= ERR_CHAIN;
            end else err_index <= err_index + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  head_addr,
  output logic               rd_req,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic               rd_ready,
  input  logic [31:0]        rd_data,
  output logic               xfer_req,
  output logic [ADDR_W-1:0]  xfer_addr,
  output logic [BYTES_W-1:0] xfer_bytes,
  output logic               xfer_write,
  output logic               xfer_udma,
  output logic [3:0]         xfer_mode,
  output logic [3:0]         xfer_burst,
  input  logic               xfer_done,
  input  logic               xfer_err,
  output logic               busy,
  output logic               done,
  output logic               fail,
  output logic [1:0]         err_code,
  output logic [IDX_W-1:0]   err_index
);
  // named internal events, visible to the bound checker
  logic              fetch_en;
  logic              fetch_last;
  logic              step_load;
  logic              step_advance;
  logic [ADDR_W-1:0] step_addr;
  sgw_desc_t         desc;
  logic              dec_last;
  logic              dec_len_zero;
  logic              dec_next_zero;
  logic [ADDR_W-1:0] dec_next;

  sgw_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (step_load),
    .load_addr (step_addr),
    .en        (fetch_en),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .desc      (desc),
    .got_all   (fetch_last)
  );

  sgw_decode #(.ADDR_W(ADDR_W)) u_decode (
    .desc      (desc),
    .buf_addr  (xfer_addr),
    .bytes     (xfer_bytes),
    .is_write  (xfer_write),
    .is_udma   (xfer_udma),
    .mode      (xfer_mode),
    .burst     (xfer_burst),
    .is_last   (dec_last),
    .len_zero  (dec_len_zero),
    .next_zero (dec_next_zero),
    .next_addr (dec_next)
  );

  sgw_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .head_addr (head_addr),
    .got_all   (fetch_last),
    .len_zero  (dec_len_zero),
    .is_last   (dec_last),
    .next_zero (dec_next_zero),
    .next_addr (dec_next),
    .xfer_done (xfer_done),
    .xfer_err  (xfer_err),
    .fetch_en  (fetch_en),
    .load      (step_load),
    .load_addr (step_addr),
    .advance   (step_advance),
    .xfer_req  (xfer_req),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .err_code  (err_code),
    .err_index (err_index)
  );
endmodule

// File: rtl/sgw_walker_chk.sv
module sgw_walker_chk
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_req,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic               rd_ready,
  input logic               fetch_last,
  input logic               xfer_req,
  input logic [ADDR_W-1:0]  xfer_addr,
  input logic [BYTES_W-1:0] xfer_bytes,
  input logic               xfer_write,
  input logic               xfer_udma,
  input logic [3:0]         xfer_mode,
  input logic [3:0]         xfer_burst,
  input logic               xfer_done,
  input logic               xfer_err,
  input logic               dec_last,
  input logic               step_advance,
  input logic [ADDR_W-1:0]  dec_next,
  input logic               busy,
  input logic               done,
  input logic               fail,
  input logic [1:0]         err_code
);
  // R1
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ready |=> rd_req && $stable(rd_addr));

  // R1
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ready && !fetch_last |=> rd_req && (rd_addr == $past(rd_addr) + ADDR_W'(4)));

  // R4
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && !xfer_done && !xfer_err |=> xfer_req &&
      $stable({xfer_addr, xfer_bytes, xfer_write, xfer_udma, xfer_mode, xfer_burst}));

  // R8
  no_empty_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> xfer_bytes != '0);

  // R4
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && xfer_req));

  // R12
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  idle_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |-> !busy);

  // R6
  follow_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_advance |=> rd_req && (rd_addr == $past(dec_next)));

  // R9
  mover_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_err |=> fail && (err_code == 2'd3));

  // R5
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && xfer_done && !xfer_err && dec_last |=> done && (err_code == 2'd0));
endmodule

bind sg_chain_walker sgw_walker_chk #(.ADDR_W(ADDR_W)) u_walker_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req       (rd_req),
  .rd_addr      (rd_addr),
  .rd_ready     (rd_ready),
  .fetch_last   (fetch_last),
  .xfer_req     (xfer_req),
  .xfer_addr    (xfer_addr),
  .xfer_bytes   (xfer_bytes),
  .xfer_write   (xfer_write),
  .xfer_udma    (xfer_udma),
  .xfer_mode    (xfer_mode),
  .xfer_burst   (xfer_burst),
  .xfer_done    (xfer_done),
  .xfer_err     (xfer_err),
  .dec_last     (dec_last),
  .step_advance (step_advance),
  .dec_next     (dec_next),
  .busy         (busy),
  .done         (done),
  .fail         (fail),
  .err_code     (err_code)
);

// File: tb/sg_chain_walker_test.sv
module sg_chain_walker_test;
  localparam int AW = 32;
  localparam int IW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] head_addr = '0;
  logic rd_req, xfer_req, busy, done, fail;
  logic [AW-1:0] rd_addr, xfer_addr;
  logic rd_ready = 1'b0;
  logic [31:0] rd_data = '0;
  logic [34:0] xfer_bytes;
  logic xfer_write, xfer_udma;
  logic [3:0] xfer_mode, xfer_burst;
  logic xfer_done = 1'b0, xfer_err = 1'b0;
  logic [1:0] err_code;
  logic [IW-1:0] err_index;

  always #10 clk = ~clk;

  sg_chain_walker #(.ADDR_W(AW), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .head_addr(head_addr),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_bytes(xfer_bytes),
    .xfer_write(xfer_write), .xfer_udma(xfer_udma), .xfer_mode(xfer_mode),
    .xfer_burst(xfer_burst), .xfer_done(xfer_done), .xfer_err(xfer_err),
    .busy(busy), .done(done), .fail(fail), .err_code(err_code), .err_index(err_index)
  );

  typedef struct {
    logic [31:0] a;
    logic [34:0] b;
    bit w;
    bit u;
    logic [3:0] m;
    logic [3:0] bu;
  } xf_t;

  logic [31:0] mem [64];
  int unsigned fq[$];
  xf_t xq[$];
  int total = 0, bad = 0, cyc = 0;
  int err_at_v = -1, mv_num = 0, mv_cnt = 0;
  bit mv_active = 0, mv_fail = 0, finished = 0;

  task automatic chk(input bit ok, input string tag, input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input int base, input logic [31:0] a, ln, fl, nx);
    mem[(base >> 2) + 0] = a;
    mem[(base >> 2) + 1] = ln;
    mem[(base >> 2) + 2] = fl;
    mem[(base >> 2) + 3] = nx;
  endtask

  // behavioural walk of the chain following the requirements
  task automatic model_walk(input logic [31:0] head, input int err_at, output int code, output int idx);
    logic [31:0] p, ad, ln, fl, nx;
    xf_t x;
    p = head; code = 0; idx = 0;
    for (int n = 0; n < 16; n++) begin
      for (int k = 0; k < 4; k++) fq.push_back(p + 4 * k);
      ad = mem[(p >> 2) & 63]; ln = mem[((p >> 2) + 1) & 63];
      fl = mem[((p >> 2) + 2) & 63]; nx = mem[((p >> 2) + 3) & 63];
      idx = n;
      if (ln == 0) begin code = 1; return; end
      x.a = ad; x.b = 35'(ln) * 35'd8; x.w = fl[5]; x.u = fl[4];
      x.m = fl[11:8]; x.bu = fl[15:12];
      xq.push_back(x);
      if (n == err_at) begin code = 3; return; end
      if (fl[7]) begin code = 0; return; end
      if (nx == 0) begin code = 2; return; end
      p = nx;
    end
  endtask

  // memory and data-mover models, compared against the reference queues on every clock
  always @(negedge clk) begin
    if (rd_req && !rd_ready) begin
      rd_ready = 1'b1;
      rd_data = mem[rd_addr[7:2]];
      if (fq.size() == 0) chk(0, "R1 unexpected fetch", rd_addr, 0);
      else begin
        int unsigned e;
        e = fq.pop_front();
        chk(rd_addr == e, "R1 fetch address", rd_addr, e);
      end
    end else rd_ready = 1'b0;

    if (xfer_done || xfer_err) begin
      xfer_done = 1'b0;
      xfer_err = 1'b0;
    end else if (xfer_req && !mv_active) begin
      mv_active = 1; mv_cnt = 2;
      mv_fail = (mv_num == err_at_v);
      mv_num++;
      if (xq.size() == 0) chk(0, "R4 unexpected transfer", xfer_addr, 0);
      else begin
        xf_t x;
        x = xq.pop_front();
        chk(xfer_addr == x.a, "R3 buffer address", xfer_addr, x.a);
        chk(xfer_bytes == x.b, "R2 byte count", xfer_bytes, x.b);
        chk(xfer_write == x.w, "R3 write flag", xfer_write, x.w);
        chk(xfer_udma == x.u, "R3 udma flag", xfer_udma, x.u);
        chk(xfer_mode == x.m, "R3 mode", xfer_mode, x.m);
        chk(xfer_burst == x.bu, "R3 burst", xfer_burst, x.bu);
      end
    end else if (mv_active) begin
      if (mv_cnt == 0) begin
        xfer_done = 1'b1;
        xfer_err = mv_fail;
        mv_active = 0;
      end else mv_cnt--;
    end
  end

  task automatic finish_up();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      finish_up();
    end
  end

  task automatic run(input logic [31:0] head, input int err_at, input bit poke);
    int code, idx, w;
    string tg;
    fq.delete(); xq.delete();
    err_at_v = err_at; mv_num = 0;
    model_walk(head, err_at, code, idx);
    tg = (code == 1) ? "R8" : (code == 2) ? "R7" : (code == 3) ? "R9" : "R5";
    @(negedge clk); head_addr = head; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R11 busy after start", busy, 1);
    if (poke) begin
      repeat (4) @(negedge clk);
      chk(busy == 1'b1, "R10 busy before second start", busy, 1);
      head_addr = 32'h80; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    w = 0;
    while (!(done || fail) && w < 3000) begin @(negedge clk); w++; end
    if (code == 0) begin
      chk(done && !fail, {tg, " done pulse"}, {done, fail}, 2'b10);
      chk(err_code == 0, "R12 code after done", err_code, 0);
    end else begin
      chk(fail && !done, {tg, " fail pulse"}, {done, fail}, 2'b01);
      chk(err_code == code, {tg, " error code"}, err_code, code);
      chk(err_index == idx, {tg, " error index"}, err_index, idx);
    end
    if (poke) chk(fq.size() == 0 && xq.size() == 0 && done, "R10 walk unchanged", fq.size() + xq.size(), 0);
    @(negedge clk);
    chk(!done && !fail, "R12 one-cycle pulse", {done, fail}, 0);
    chk(!busy, "R11 idle after end", busy, 0);
    chk(fq.size() == 0, "R1 all fetches made", fq.size(), 0);
    chk(xq.size() == 0, "R4 all transfers made", xq.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    // chain A: 0x20 -> 0x30 -> 0x50 (end)
    put(32'h20, 32'h1000, 32'd4,     32'h0000_2530, 32'h30);
    put(32'h30, 32'h2000, 32'd1,     32'h0000_0300, 32'h50);
    put(32'h50, 32'h3000, 32'h100,   32'h0000_1290, 32'h0);
    // single entry marked last with a live pointer
    put(32'h80, 32'h4000, 32'd2,     32'h0000_f4a0, 32'h20);
    // broken chain: second entry unmarked with zero pointer
    put(32'h90, 32'h5000, 32'd3,     32'h0000_0010, 32'hA0);
    put(32'hA0, 32'h6000, 32'd5,     32'h0000_0120, 32'h0);
    // zero length in the second entry
    put(32'hB0, 32'h7000, 32'd7,     32'h0000_0000, 32'hC0);
    put(32'hC0, 32'h8000, 32'd0,     32'h0000_0080, 32'h0);
    // large length at the top of the field
    put(32'hD0, 32'h9000, 32'hffff_ffff, 32'h0000_3580, 32'h0);

    repeat (3) @(negedge clk);
    chk(!busy && !rd_req && !xfer_req && !done && !fail, "R11 reset state",
        {busy, rd_req, xfer_req, done, fail}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rd_req, "R11 idle without start", {busy, rd_req}, 0);

    run(32'h20, -1, 0);  // R6 three-entry chain, R5 end
    run(32'h80, -1, 0);  // R5 stop on end flag with live pointer
    run(32'h90, -1, 0);  // R7 broken chain
    run(32'hB0, -1, 0);  // R8 zero length
    run(32'h20, 2, 0);   // R9 mover error on last entry, error over done
    run(32'h20, 0, 0);   // R9 mover error on first entry
    run(32'hD0, -1, 0);  // R2 maximum length
    run(32'h20, -1, 1);  // R10 second start ignored
    finish_up();
  end
endmodule